// File: doc/BRIEF.md
# UART Interrupt Arbiter

This block gathers the five interrupt causes of an asynchronous serial port into one interrupt line and one identification byte. The serial datapaths sit outside it and report single-cycle events: a receive error, a received byte becoming available, the transmit holding stage draining, and a change on a modem handshake input. The block also runs a receive-idle timer of its own in FIFO mode. It keeps one pending flag per cause, masks each flag with a host-written enable bit, and shows the most urgent unmasked cause as a 3-bit code.

The host clears a cause through the register access that services it. The surrounding register decoder gives each such access to this block as a one-cycle strobe. An external enable bit gates the interrupt pin, so software can keep the port quiet while it still polls the identification byte.

Top module: `uart_irq_arbiter`

## Requirements
- R1: The enable byte reads back written bits 3..0 (bit 0 = received data and idle timeout, bit 1 = transmit empty, bit 2 = receive error, bit 3 = modem change), and bits 7..4 read zero. Reset clears the enable byte.
- R2: Bit 0 of the identification byte is 1 when no enabled cause is pending and 0 otherwise. With nothing pending, bits 3..1 read 000.
- R3: Bits 3..1 report the highest-priority enabled pending cause. Priority runs from receive error (011), then received data (010), then idle timeout (100), then transmit empty (001), down to modem change (000).
- R4: Bits 7..6 read 11 while FIFO mode is on and 00 while it is off. Bits 5..4 read 0.
- R5: In FIFO mode, while the receive FIFO is non-empty and neither read nor pushed, the timeout cause is set on the edge that counts the CHAR_TIMES*OVERSAMPLE*frame_bits-th consecutive oversample tick. A data read, a push, an empty FIFO or FIFO mode off restarts the count.
- R6: A receive-error cause clears on a line-status read strobe. Received-data and timeout causes clear on a receive-data read strobe.
- R7: The transmit-empty cause clears on a transmit-data write strobe, or on an identification read strobe in a cycle where transmit-empty is the reported cause. An identification read while another cause is reported leaves it pending.
- R8: The modem-change cause clears on a modem-status read strobe.
- R9: irq_out is high exactly when some enabled cause is pending and irq_pin_en is 1.
- R10: A cause that is pending but masked stays pending and is reported once it is enabled. A lower cause is reported as soon as every higher one has cleared.
- R11: When a cause's event and its clearing strobe arrive in the same cycle, the cause is left pending.
- R12: After reset no cause is pending. The identification byte reads 0x01 with FIFO mode off and irq_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr | input | 1 | Write strobe for the enable byte |
| en_wdata | input | 4 | Enable bits to write |
| en_rdata | output | 8 | Enable byte read value |
| fifo_mode | input | 1 | FIFO mode is on |
| irq_pin_en | input | 1 | Gates the interrupt pin |
| frame_bits | input | FRAME_W | Bits per character, start and stop included |
| tick16 | input | 1 | Oversample tick |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| rx_push | input | 1 | A character entered the receive FIFO |
| ev_line_err | input | 1 | Receive error event |
| ev_rx_data | input | 1 | Received data available event |
| ev_tx_empty | input | 1 | Transmit holding stage became empty |
| ev_modem_chg | input | 1 | Modem input change event |
| rd_line_stat | input | 1 | Line-status read strobe |
| rd_rx_data | input | 1 | Receive-data read strobe |
| rd_id | input | 1 | Identification byte read strobe |
| wr_tx_data | input | 1 | Transmit-data write strobe |
| rd_modem_stat | input | 1 | Modem-status read strobe |
| id_rdata | output | 8 | Identification byte |
| irq_out | output | 1 | Interrupt output |

## Verification
The bench builds the arbiter with CHAR_TIMES=4, OVERSAMPLE=4 and FRAME_W=4. At ten bits per frame the idle threshold is then 160 ticks, so the run can reach the exact firing edge, a restart by a push just before it, and a sparser tick pattern within a few hundred cycles. Because the frame-length input is four bits wide, the same build also covers the longest frames the counter width must hold.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_CAUSE = 5;
    localparam int EN_BITS   = 4;

    typedef enum logic [2:0] {
        ID_MODEM  = 3'b000,
        ID_TXE    = 3'b001,
        ID_RXDATA = 3'b010,
        ID_LINE   = 3'b011,
        ID_TMO    = 3'b100
    } irq_id_e;

    // most significant field is the most urgent cause
    typedef struct packed {
        logic line;
        logic rxdata;
        logic tmo;
        logic txe;
        logic modem;
    } cause_t;

    typedef struct packed {
        logic    any;
        irq_id_e id;
    } report_t;

    function automatic irq_id_e id_at(int rank);
        case (rank)
            0:       return ID_LINE;
            1:       return ID_RXDATA;
            2:       return ID_TMO;
            3:       return ID_TXE;
            default: return ID_MODEM;
        endcase
    endfunction

    function automatic report_t pick_highest(cause_t c);
        logic [NUM_CAUSE-1:0] v;
        report_t r;
        v     = c;
        r.any = 1'b0;
        r.id  = ID_MODEM;
        for (int i = 0; i < NUM_CAUSE; i++) begin
            if (!r.any && v[NUM_CAUSE-1-i]) begin
                r.any = 1'b1;
                r.id  = id_at(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import uart_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [EN_BITS-1:0] wdata,
    output logic [EN_BITS-1:0] en_q
);
    always_ff @(posedge clk) begin
        if (rst)     en_q <= '0;
        else if (wr) en_q <= wdata;
    end
endmodule

// File: rtl/irq_char_timer.sv
module irq_char_timer #(
    parameter int CHAR_TIMES = 4,
    parameter int OVERSAMPLE = 16,
    parameter int FRAME_W    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fifo_mode,
    input  logic               rx_nonempty,
    input  logic               rx_push,
    input  logic               rx_read,
    input  logic               tick,
    input  logic [FRAME_W-1:0] frame_bits,
    output logic               fire
);
    localparam int CNT_W = $clog2(CHAR_TIMES * OVERSAMPLE * (2 ** FRAME_W));

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             restart;

    assign limit   = CNT_W'(CHAR_TIMES * OVERSAMPLE)
                   * {{(CNT_W - FRAME_W){1'b0}}, frame_bits};
    assign restart = !fifo_mode || !rx_nonempty || rx_read || rx_push;
    assign fire    = !restart && tick && (cnt_q < limit)
                   && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart)              cnt_q <= '0;
        else if (tick && cnt_q < limit)  cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/irq_cause_latches.sv
module irq_cause_latches
    import uart_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_t set_v,
    input  cause_t clr_v,
    output cause_t pend_q
);
    // a new event outweighs a clearing access in the same cycle
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= set_v | (pend_q & ~clr_v);
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  cause_t  active,
    output report_t rep
);
    always_comb rep = pick_highest(active);
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uart_irq_pkg::*;
#(
    parameter int CHAR_TIMES = 4,
    parameter int OVERSAMPLE = 16,
    parameter int FRAME_W    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_wr,
    input  logic [3:0]         en_wdata,
    output logic [7:0]         en_rdata,
    input  logic               fifo_mode,
    input  logic               irq_pin_en,
    input  logic [FRAME_W-1:0] frame_bits,
    input  logic               tick16,
    input  logic               rx_nonempty,
    input  logic               rx_push,
    input  logic               ev_line_err,
    input  logic               ev_rx_data,
    input  logic               ev_tx_empty,
    input  logic               ev_modem_chg,
    input  logic               rd_line_stat,
    input  logic               rd_rx_data,
    input  logic               rd_id,
    input  logic               wr_tx_data,
    input  logic               rd_modem_stat,
    output logic [7:0]         id_rdata,
    output logic               irq_out
);
    logic [EN_BITS-1:0] en_q;
    logic               tmo_fire;
    cause_t             set_v, clr_v, pend, active;
    report_t            rep;

    irq_enable_reg u_en (
        .clk   (clk),
        .rst   (rst),
        .wr    (en_wr),
        .wdata (en_wdata),
        .en_q  (en_q)
    );

    irq_char_timer #(
        .CHAR_TIMES (CHAR_TIMES),
        .OVERSAMPLE (OVERSAMPLE),
        .FRAME_W    (FRAME_W)
    ) u_tmr (
        .clk         (clk),
        .rst         (rst),
        .fifo_mode   (fifo_mode),
        .rx_nonempty (rx_nonempty),
        .rx_push     (rx_push),
        .rx_read     (rd_rx_data),
        .tick        (tick16),
        .frame_bits  (frame_bits),
        .fire        (tmo_fire)
    );

    always_comb begin
        set_v.line   = ev_line_err;
        set_v.rxdata = ev_rx_data;
        set_v.tmo    = tmo_fire;
        set_v.txe    = ev_tx_empty;
        set_v.modem  = ev_modem_chg;

        clr_v.line   = rd_line_stat;
        clr_v.rxdata = rd_rx_data;
        clr_v.tmo    = rd_rx_data;
        clr_v.txe    = wr_tx_data || (rd_id && rep.any && rep.id == ID_TXE);
        clr_v.modem  = rd_modem_stat;
    end

    irq_cause_latches u_lat (
        .clk    (clk),
        .rst    (rst),
        .set_v  (set_v),
        .clr_v  (clr_v),
        .pend_q (pend)
    );

    always_comb begin
        active.line   = pend.line   & en_q[2];
        active.rxdata = pend.rxdata & en_q[0];
        active.tmo    = pend.tmo    & en_q[0];
        active.txe    = pend.txe    & en_q[1];
        active.modem  = pend.modem  & en_q[3];
    end

    irq_prio_enc u_enc (
        .active (active),
        .rep    (rep)
    );

    assign en_rdata = {4'b0000, en_q};
    assign id_rdata = {{2{fifo_mode}}, 2'b00, rep.id, ~rep.any};
    assign irq_out  = rep.any & irq_pin_en;

endmodule

// File: rtl/uart_irq_arbiter_chk.sv
module uart_irq_arbiter_chk (
    input logic       clk,
    input logic       rst,
    input logic       en_wr,
    input logic [7:0] en_rdata,
    input logic       fifo_mode,
    input logic       irq_pin_en,
    input logic       ev_line_err,
    input logic       ev_tx_empty,
    input logic       ev_modem_chg,
    input logic       rd_line_stat,
    input logic       wr_tx_data,
    input logic       rd_modem_stat,
    input logic [7:0] id_rdata,
    input logic       irq_out
);
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        en_rdata[7:4] == 4'b0000);

    p_none_bit_r2: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> !id_rdata[0]);

    p_line_first_r3: assert property (@(posedge clk) disable iff (rst)
        (ev_line_err && en_rdata[2] && !en_wr) |=> id_rdata[3:0] == 4'b0110);

    p_mode_bits_r4: assert property (@(posedge clk) disable iff (rst)
        id_rdata[5:4] == 2'b00 && id_rdata[7:6] == {2{fifo_mode}});

    p_line_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_line_stat && !ev_line_err) |=> id_rdata[3:1] != 3'b011);

    p_txe_write_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_tx_data && !ev_tx_empty) |=> id_rdata[3:1] != 3'b001);

    p_modem_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_modem_stat && !ev_modem_chg) |=> (id_rdata[0] || id_rdata[3:1] != 3'b000));

    p_pin_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !irq_pin_en |-> !irq_out);
endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk chk_i (.*);

// File: tb/uart_irq_arbiter_tb_top.sv
module uart_irq_arbiter_tb_top;
    localparam int CT = 4;
    localparam int OS = 4;
    localparam int FW = 4;

    logic clk = 0;
    logic rst = 1;
    logic en_wr = 0;
    logic [3:0] en_wdata = 0;
    logic [7:0] en_rdata;
    logic fifo_mode = 0, irq_pin_en = 0;
    logic [FW-1:0] frame_bits = 4'd10;
    logic tick16 = 0, rx_nonempty = 0, rx_push = 0;
    logic ev_line_err = 0, ev_rx_data = 0, ev_tx_empty = 0, ev_modem_chg = 0;
    logic rd_line_stat = 0, rd_rx_data = 0, rd_id = 0, wr_tx_data = 0, rd_modem_stat = 0;
    logic [7:0] id_rdata;
    logic irq_out;

    uart_irq_arbiter #(.CHAR_TIMES(CT), .OVERSAMPLE(OS), .FRAME_W(FW)) dut_i (.*);

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    string cur_req = "R12";
    bit done = 0;

    // reference state
    bit m_ls, m_rd, m_to, m_tx, m_ms;
    int m_en, m_cnt;

    function automatic int ref_code(output bit any);
        any = 1;
        if (m_ls && m_en[2]) return 3;
        if (m_rd && m_en[0]) return 2;
        if (m_to && m_en[0]) return 4;
        if (m_tx && m_en[1]) return 1;
        if (m_ms && m_en[3]) return 0;
        any = 0;
        return 0;
    endfunction

    function automatic int ref_id();
        bit any;
        int c;
        c = ref_code(any);
        return (fifo_mode ? 8'hC0 : 0) | (c << 1) | (any ? 0 : 1);
    endfunction

    task automatic model_edge();
        bit any, fire, restart;
        int c, lim;
        c = ref_code(any);
        lim = CT * OS * int'(frame_bits);
        fire = 0;
        restart = !fifo_mode || !rx_nonempty || rd_rx_data || rx_push;
        if (rst) begin
            m_ls = 0; m_rd = 0; m_to = 0; m_tx = 0; m_ms = 0; m_en = 0; m_cnt = 0;
            return;
        end
        if (restart) m_cnt = 0;
        else if (tick16 && m_cnt < lim) begin
            if (m_cnt == lim - 1) fire = 1;
            m_cnt++;
        end
        m_ls = ev_line_err | (m_ls & !rd_line_stat);
        m_rd = ev_rx_data | (m_rd & !rd_rx_data);
        m_to = fire | (m_to & !rd_rx_data);
        m_tx = ev_tx_empty | (m_tx & !(wr_tx_data || (rd_id && any && c == 1)));
        m_ms = ev_modem_chg | (m_ms & !rd_modem_stat);
        if (en_wr) m_en = int'(en_wdata);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        bit any;
        int c;
        @(posedge clk);
        model_edge();
        #2;
        c = ref_code(any);
        chk(cur_req, int'(id_rdata), ref_id());
        chk(cur_req, int'(irq_out), int'(any && irq_pin_en));
        chk(cur_req, int'(en_rdata), m_en);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        steps(2);
        rst = 0;
        step();
        // R12: reset state, explicit values
        chk("R12", int'(id_rdata), 8'h01);
        chk("R12", int'(irq_out), 0);
        chk("R12", int'(en_rdata), 0);

        // R1: enable byte
        cur_req = "R1";
        en_wr = 1; en_wdata = 4'b0101; step(); en_wr = 0;
        chk("R1", int'(en_rdata), 8'h05);
        en_wr = 1; en_wdata = 4'b0000; step(); en_wr = 0;

        // R10: masked pending is kept
        cur_req = "R10";
        irq_pin_en = 1;
        ev_tx_empty = 1; step(); ev_tx_empty = 0;
        step();
        chk("R10", int'(id_rdata), 8'h01);
        en_wr = 1; en_wdata = 4'b0010; step(); en_wr = 0;
        chk("R10", int'(id_rdata), 8'h02);
        chk("R9", int'(irq_out), 1);
        wr_tx_data = 1; step(); wr_tx_data = 0;
        chk("R7", int'(id_rdata), 8'h01);

        // R3 R6 R7 R8 R4: all causes, service in order
        cur_req = "R3";
        fifo_mode = 1;
        en_wr = 1; en_wdata = 4'hF; step(); en_wr = 0;
        ev_line_err = 1; ev_rx_data = 1; ev_tx_empty = 1; ev_modem_chg = 1;
        step();
        ev_line_err = 0; ev_rx_data = 0; ev_tx_empty = 0; ev_modem_chg = 0;
        chk("R3", int'(id_rdata), 8'hC6);
        cur_req = "R7";
        rd_id = 1; step(); rd_id = 0;
        chk("R7", int'(id_rdata), 8'hC6);
        cur_req = "R6";
        rd_line_stat = 1; step(); rd_line_stat = 0;
        chk("R6", int'(id_rdata), 8'hC4);
        rd_rx_data = 1; step(); rd_rx_data = 0;
        chk("R10", int'(id_rdata), 8'hC2);
        cur_req = "R7";
        rd_id = 1; step(); rd_id = 0;
        chk("R7", int'(id_rdata), 8'hC0);
        cur_req = "R11";
        ev_modem_chg = 1; rd_modem_stat = 1; step(); ev_modem_chg = 0; rd_modem_stat = 0;
        chk("R11", int'(id_rdata), 8'hC0);
        cur_req = "R8";
        rd_modem_stat = 1; step(); rd_modem_stat = 0;
        chk("R8", int'(id_rdata), 8'hC1);
        chk("R2", int'(irq_out), 0);

        // R9: pin gate
        cur_req = "R9";
        ev_modem_chg = 1; irq_pin_en = 0; step(); ev_modem_chg = 0;
        chk("R9", int'(irq_out), 0);
        chk("R2", int'(id_rdata), 8'hC0);
        irq_pin_en = 1; step();
        chk("R9", int'(irq_out), 1);
        rd_modem_stat = 1; step(); rd_modem_stat = 0;

        // R5: idle timeout, threshold 4*4*10 = 160 ticks
        cur_req = "R5";
        tick16 = 1; rx_nonempty = 1; frame_bits = 4'd10;
        steps(100);
        rx_push = 1; step(); rx_push = 0;
        steps(159);
        chk("R5", int'(id_rdata), 8'hC1);
        step();
        chk("R5", int'(id_rdata), 8'hC8);
        rd_rx_data = 1; step(); rd_rx_data = 0;
        chk("R6", int'(id_rdata), 8'hC1);
        // sparse ticks, frame of 7 -> 112 ticks
        frame_bits = 4'd7;
        for (int i = 0; i < 230; i++) begin
            tick16 = (i % 2 == 0);
            step();
        end
        chk("R5", int'(id_rdata), 8'hC8);
        rd_rx_data = 1; step(); rd_rx_data = 0;
        // no timeout with FIFO mode off
        cur_req = "R4";
        fifo_mode = 0; tick16 = 1;
        steps(300);
        chk("R4", int'(id_rdata), 8'h01);
        rx_nonempty = 0;

        // R10: lower cause follows higher
        cur_req = "R10";
        ev_rx_data = 1; ev_tx_empty = 1; step(); ev_rx_data = 0; ev_tx_empty = 0;
        chk("R10", int'(id_rdata), 8'h04);
        rd_rx_data = 1; step(); rd_rx_data = 0;
        chk("R10", int'(id_rdata), 8'h02);
        wr_tx_data = 1; step(); wr_tx_data = 0;
        chk("R2", int'(id_rdata), 8'h01);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule